// File: doc/BRIEF.md
# Shared Memory Atomic Reservation Unit

This block is a small word-addressed memory shared by several hardware threads through a single arbitrated port. Each cycle at most one requester is accepted. The accepted operation completes at the next clock edge. A response pulse with its data returns to that requester one cycle after acceptance. The unit offers plain load and store, a load-linked / store-conditional pair, and a test-and-set that reads and writes a word indivisibly.

The unit keeps one reservation per requester: an address and a valid bit. A load-linked sets the requester's reservation. A store-conditional writes only while that reservation is still valid. Any write to a reserved word, whoever issues it, breaks every reservation on that word, including the writer's own. Because only one operation is performed per cycle, no other access can reach a word between the read and the write of an atomic operation. Lock words use 0 for free and 1 for held, and a plain store of 0 releases a lock.

Requests use valid/ready. A requester raises its valid bit with the operation, address and write data, and holds them until it sees its ready bit high at a clock edge. Ready is never high without valid. Responses cannot be stalled: the requester must take the response pulse in the cycle it appears.

Top module: `atomic_mem_unit`

## Requirements
- R1: Reset clears every memory word to 0, invalidates all reservations, drops all response pulses, and restarts arbitration at requester 0.
- R2: A store (op code 1) writes its data to the addressed word and responds with data 0. A load (op code 0) responds with the word's current value.
- R3: At most one ready bit is high per cycle, and only for a requester whose valid bit is high. When any request is pending, one is granted. The grant goes to the first valid requester at or after the one following the previous grantee, in cyclic order.
- R4: One cycle after a grant, only that requester's response-valid bit is high, and the response data holds that operation's result. Otherwise no response-valid bit is high.
- R5: A load-linked (op code 2) returns the word and sets the requester's reservation to that address, replacing any earlier reservation it held.
- R6: A store-conditional (op code 3) succeeds only if the requester's reservation is valid and on the same address. On success it writes its data and responds with 1. On failure it responds with 0 and memory is unchanged.
- R7: Every write to an address clears the reservations of all requesters on that address, including the writer's own. This covers a store, a successful store-conditional, and a test-and-set that writes.
- R8: A test-and-set (op code 4) returns the old word. If the old word was 0 it writes 1; otherwise the word is left as it was.
- R9: Op codes 5 to 7 behave as a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NREQ | Request pending, one bit per requester |
| req_ready | output | NREQ | Request accepted this cycle, one-hot or zero |
| req_op | input | NREQ*3 | Op code per requester, 3 bits each |
| req_addr | input | NREQ*AW | Word address per requester |
| req_wdata | input | NREQ*DW | Write data per requester |
| resp_valid | output | NREQ | One-cycle response pulse, one bit per requester |
| resp_data | output | DW | Result of the answered operation |

## Verification
The interesting collisions happen across consecutive grants. A store or test-and-set from one requester can land on a word that another requester has reserved, right before that requester's store-conditional. Several requesters can also ask for the same lock word in the same cycle. The bench provokes both with directed sequences and with random traffic confined to four addresses, so reservations and conflicting writes interleave often. Each response and each grant is compared against a bench model of the memory, the reservations and the cyclic arbitration order.

// File: rtl/atomic_mem_pkg.sv
package atomic_mem_pkg;
  localparam int OPW = 3;
  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_LL    = 3'd2,
    OP_SC    = 3'd3,
    OP_TAS   = 3'd4
  } mem_op_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx,
  output logic          any
);
  logic [IW-1:0] ptr;

  always_comb begin
    grant = '0;
    gidx  = '0;
    any   = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (!any && req[j]) begin
        any      = 1'b1;
        grant[j] = 1'b1;
        gidx     = IW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (any)
      ptr <= (int'(gidx) == N - 1) ? '0 : gidx + 1'b1;
  end
endmodule

// File: rtl/resv_table.sv
module resv_table #(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [IW-1:0]   set_id,
  input  logic [AW-1:0]   set_addr,
  input  logic            kill_en,
  input  logic [AW-1:0]   kill_addr,
  output logic [N-1:0]    rv,
  output logic [N*AW-1:0] ra
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic          v_q;
    logic [AW-1:0] a_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        a_q <= '0;
      end else if (set_en && int'(set_id) == i) begin
        v_q <= 1'b1;
        a_q <= set_addr;
      end else if (kill_en && v_q && a_q == kill_addr) begin
        v_q <= 1'b0;
      end
    end
    assign rv[i]             = v_q;
    assign ra[i*AW +: AW]    = a_q;
  end
endmodule

// File: rtl/word_mem.sv
module word_mem #(
  parameter int AW = 4,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
  import atomic_mem_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req_valid,
  output logic [NREQ-1:0]   req_ready,
  input  logic [NREQ*3-1:0] req_op,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic [NREQ*DW-1:0] req_wdata,
  output logic [NREQ-1:0]   resp_valid,
  output logic [DW-1:0]     resp_data
);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [IW-1:0]      gidx;
  logic               gnt_any;
  logic [OPW-1:0]     sel_op;
  logic [AW-1:0]      sel_addr;
  logic [DW-1:0]      sel_wdata;
  logic [DW-1:0]      cur_word;
  logic [NREQ-1:0]    rv;
  logic [NREQ*AW-1:0] ra;
  logic               own_ok;
  logic               wr_en;
  logic [DW-1:0]      wr_data;
  logic               ll_set;
  logic [DW-1:0]      rsp_next;

  rr_arbiter #(.N(NREQ), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .grant(req_ready), .gidx(gidx), .any(gnt_any)
  );

  assign sel_op    = req_op[gidx*OPW +: OPW];
  assign sel_addr  = req_addr[gidx*AW +: AW];
  assign sel_wdata = req_wdata[gidx*DW +: DW];
  assign own_ok    = rv[gidx] && (ra[gidx*AW +: AW] == sel_addr);

  word_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(sel_addr),
    .wr_data(wr_data), .rd_addr(sel_addr), .rd_data(cur_word)
  );

  always_comb begin
    wr_en    = 1'b0;
    wr_data  = sel_wdata;
    ll_set   = 1'b0;
    rsp_next = cur_word;
    if (gnt_any) begin
      case (sel_op)
        OP_STORE: begin
          wr_en    = 1'b1;
          rsp_next = '0;
        end
        OP_LL: ll_set = 1'b1;
        OP_SC: begin
          wr_en    = own_ok;
          rsp_next = DW'(own_ok);
        end
        OP_TAS: begin
          wr_en   = (cur_word == '0);
          wr_data = DW'(1);
        end
        default: ;
      endcase
    end
  end

  resv_table #(.N(NREQ), .AW(AW), .IW(IW)) u_resv (
    .clk(clk), .rst_n(rst_n),
    .set_en(ll_set), .set_id(gidx), .set_addr(sel_addr),
    .kill_en(wr_en), .kill_addr(sel_addr),
    .rv(rv), .ra(ra)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= '0;
      resp_data  <= '0;
    end else begin
      resp_valid <= req_ready;
      if (gnt_any) resp_data <= rsp_next;
    end
  end
endmodule

// File: rtl/atomic_mem_unit_chk.sv
module atomic_mem_unit_chk #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_valid,
  input logic [NREQ-1:0] req_ready,
  input logic [NREQ-1:0] resp_valid
);
  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  // R3
  grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);
  // R3
  work_conserving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid) |-> (|req_ready));
  // R4
  resp_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> (resp_valid == $past(req_ready)));
  // R4
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_ready) |=> (resp_valid == '0));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (resp_valid == '0));
endmodule

bind atomic_mem_unit atomic_mem_unit_chk #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_atomic_mem_unit.sv
module tb_atomic_mem_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_ready;
  logic [N*3-1:0]  req_op = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0]    resp_valid;
  logic [DW-1:0]   resp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_mem_unit #(.NREQ(N), .AW(AW), .DW(DW)) dut (.*);

  int checks = 0;
  int errors = 0;

  // pending requests
  logic          pv [N];
  logic [2:0]    pop [N];
  logic [AW-1:0] pad [N];
  logic [DW-1:0] pda [N];
  // model
  logic [DW-1:0] mm [1 << AW];
  logic          mrv [N];
  logic [AW-1:0] mra [N];
  int            rr_ptr;
  // expected response
  int            last_g;
  logic [DW-1:0] exp_d;
  string         exp_tag;
  string         note;

  task automatic chk(input logic ok, input string tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void mwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    mm[a] = d;
    for (int j = 0; j < N; j++)
      if (mrv[j] && mra[j] == a) mrv[j] = 1'b0;
  endfunction

  function automatic logic [DW-1:0] mexec(input int g);
    logic [DW-1:0] cur;
    logic ok;
    cur = mm[pad[g]];
    case (pop[g])
      3'd1: begin mwrite(pad[g], pda[g]); exp_tag = "R2"; return '0; end
      3'd2: begin mrv[g] = 1'b1; mra[g] = pad[g]; exp_tag = "R5"; return cur; end
      3'd3: begin
        ok = mrv[g] && mra[g] == pad[g];
        if (ok) mwrite(pad[g], pda[g]);
        exp_tag = "R6";
        return DW'(ok);
      end
      3'd4: begin
        if (cur == '0) mwrite(pad[g], DW'(1));
        exp_tag = "R8";
        return cur;
      end
      3'd0: begin exp_tag = "R2"; return cur; end
      default: begin exp_tag = "R9"; return cur; end
    endcase
  endfunction

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      req_valid[i]          = pv[i];
      req_op[i*3 +: 3]      = pop[i];
      req_addr[i*AW +: AW]  = pad[i];
      req_wdata[i*DW +: DW] = pda[i];
    end
  endtask

  // drive at negedge, check grant, advance model
  task automatic fire();
    logic [N-1:0] eg;
    drive();
    #1;
    eg = '0;
    last_g = -1;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (rr_ptr + k) % N;
      if (last_g < 0 && pv[j]) last_g = j;
    end
    if (last_g >= 0) begin
      eg[last_g] = 1'b1;
      rr_ptr = (last_g + 1) % N;
      exp_d = mexec(last_g);
    end
    chk(req_ready == eg, "R3 grant", DW'(req_ready), DW'(eg));
  endtask

  // next negedge: check the response to the last grant
  task automatic tick();
    logic [N-1:0] ev;
    @(negedge clk);
    ev = '0;
    if (last_g >= 0) ev[last_g] = 1'b1;
    chk(resp_valid == ev, "R4 resp_valid", DW'(resp_valid), DW'(ev));
    if (last_g >= 0) begin
      chk(resp_data == exp_d, {exp_tag, note, " resp_data"}, resp_data, exp_d);
      pv[last_g] = 1'b0;
    end
    last_g = -1;
  endtask

  function automatic logic busy();
    for (int i = 0; i < N; i++) if (pv[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run();
    fire();
    tick();
    while (busy()) begin
      fire();
      tick();
    end
  endtask

  function automatic void post(input int i, input int op, input int a, input logic [DW-1:0] d);
    pv[i] = 1'b1; pop[i] = 3'(op); pad[i] = AW'(a); pda[i] = d;
  endfunction

  task automatic one(input int i, input int op, input int a, input logic [DW-1:0] d,
                     input string n);
    note = n;
    post(i, op, a, d);
    run();
    note = "";
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin
      pv[i] = 1'b0; pop[i] = '0; pad[i] = '0; pda[i] = '0;
      mrv[i] = 1'b0; mra[i] = '0;
    end
    for (int a = 0; a < (1 << AW); a++) mm[a] = '0;
    rr_ptr = 0; last_g = -1; note = ""; exp_tag = ""; exp_d = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset, memory zero
    tick();
    chk(req_ready == '0, "R1 ready idle", DW'(req_ready), '0);
    one(2, 0, 3, '0, " R1 zero word");
    one(1, 3, 3, 32'h55, " R1 no reservation");
    // R2: store and load in the same cycle
    post(0, 1, 5, 32'hA5A5_0001);
    post(1, 0, 5, '0);
    run();
    // R5 / R6: reservation then success
    one(2, 2, 7, '0, "");
    one(2, 3, 7, 32'h77, " success");
    one(0, 0, 7, '0, " R6 written");
    // R7: another requester's store breaks the reservation
    one(2, 2, 7, '0, "");
    one(3, 1, 7, 32'h1234, "");
    one(2, 3, 7, 32'hDEAD, " R7 broken by store");
    one(1, 0, 7, '0, " R6 fail leaves word");
    // R7: own successful SC clears own reservation
    one(0, 2, 8, '0, "");
    one(0, 3, 8, 32'h8, "");
    one(0, 3, 8, 32'h9, " R7 own write clears");
    // R5: newer reservation replaces older
    one(0, 2, 1, '0, "");
    one(0, 2, 2, '0, "");
    one(0, 3, 1, 32'h11, " R5 replaced");
    // R8: test-and-set lock cycle
    one(1, 4, 9, '0, " acquire");
    one(3, 4, 9, '0, " held");
    one(1, 1, 9, '0, " R8 release");
    one(3, 4, 9, '0, " reacquire");
    // R7: test-and-set write breaks reservation
    one(0, 2, 10, '0, "");
    one(1, 4, 10, '0, "");
    one(0, 3, 10, 32'h3, " R7 broken by tas");
    // R3: all four contend for one lock word
    for (int i = 0; i < N; i++) post(i, 4, 12, '0);
    note = " R3 contention";
    run();
    note = "";
    // R9: spare op codes read
    one(2, 6, 5, '0, "");
    one(3, 5, 9, '0, "");
    // random traffic on four words
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++)
        if (!pv[i] && ($urandom % 3) == 0)
          post(i, int'($urandom % 8) % 5 + (($urandom % 16) == 0 ? 5 : 0),
               int'($urandom % 4), (($urandom % 2) == 0) ? DW'(0) : DW'($urandom));
      fire();
      tick();
    end
    while (busy()) begin
      fire();
      tick();
    end
    // final sweep of all words
    for (int a = 0; a < (1 << AW); a++) one(a % N, 0, a, '0, " sweep");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule